// File: doc/BRIEF.md
# Dual-ratio fractional clock divider

The block derives a slow, nearly exact output rate (for example about 32768 Hz from a 24 MHz clock) from a fast input clock, using a divisor that has a fractional part. It alternates between two integer divisors. First, a group of periods that each last N0 input cycles runs. Then a group of periods that each last N1 input cycles runs. The whole pattern repeats. Group A holds M0+1 periods and group B holds M1+1 periods, so the mean divisor is (N0*(M0+1) + N1*(M1+1)) / (M0+M1+2). With N0 = 733, N1 = 732, M0 = 1 and M1 = 2, a 24 MHz input gives a mean divisor of about 732.4, which is an output near 32768 Hz.

Two 32-bit configuration words set the block up. The first word holds both divisors, an output-shape selector and a run bit. The second word holds both repeat fields. The block keeps written divisors and repeat fields in shadow registers. It copies them into the working set only when a full pattern completes, or when the divider starts from idle, so no period is ever a mix of old and new settings. The run bit and the output-shape selector act at once.

The controller has three states. IDLE is entered on reset and whenever the run bit is 0. GROUP_A counts periods of N0. GROUP_B counts periods of N1. The transitions are:
- START (IDLE to GROUP_A) happens when the run bit is 1. It loads the working set.
- A_DONE (GROUP_A to GROUP_B) happens at the end of the last N0 period.
- WRAP (GROUP_B to GROUP_A) happens at the end of the last N1 period. It reloads the working set.
- HALT (any state to IDLE) happens whenever the run bit is 0.

Top module: `dual_ratio_divider`

## Requirements
- R1: After reset, `div_o` is 0 and stays 0 until a configuration with the run bit set is written.
- R2: Word 0 has this layout: N0 in bits 11:0, N1 in bits 23:12, the output-shape selector in bits 29:28 and the run bit in bit 31. Word 1 has this layout: M0 in bits 11:0 and M1 in bits 23:12. Any other bits are ignored.
- R3: The divider counts only while the run bit is 1. After a word-0 write that sets the run bit from idle, the first output pulse is seen N0+2 cycles after the write cycle.
- R4: The periods run in this order: M0+1 periods of N0 input cycles each, then M1+1 periods of N1 input cycles each, and the pattern repeats without a gap.
- R5: When the selector is 01 (pulse shape), `div_o` is high for exactly one input cycle, at the end of each period.
- R6: When the selector is 10 (clock shape), `div_o` rises at the start of each period and stays high for floor(N/2) cycles of that period's divisor N. It is low for the rest of the period.
- R7: When the selector is 00 or 11, `div_o` stays 0 while the divider keeps counting. Selecting 01 later shows pulses at once, with no restart.
- R8: New values of N0, N1, M0 and M1 take effect only after the last N1 period of the pattern in progress.
- R9: Clearing the run bit forces `div_o` to 0 from the second cycle after the write and returns the divider to IDLE. A later enable restarts with a fresh N0 group.
- R10: A divisor field below 2 is treated as 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg0_we_i | input | 1 | Write strobe for configuration word 0 |
| cfg0_wd_i | input | 32 | Word 0 data: N0, N1, output-shape selector, run bit |
| cfg1_we_i | input | 1 | Write strobe for configuration word 1 |
| cfg1_wd_i | input | 32 | Word 1 data: M0, M1 |
| div_o | output | 1 | Divided output, as a pulse or a clock |

## Verification
The bench sweeps every combination of small divisors (2 to 5) and small repeat fields (0 to 2). For each combination it predicts every pulse arrival arithmetically from the start cycle. An off-by-one in a group length would shift every later pulse. So would a swapped field or a mishandled M of zero. The bench changes the divisors in the middle of a pattern. A design that applied them at once would move pulses inside the current pattern rather than after its last N1 period. It also covers divisor fields of 0 and 1, odd divisors in clock shape (the high width must round down), the quiet selector codes (the counter must keep running), and disable followed by re-enable (a design that kept stale counters would restart in the wrong group or at the wrong phase).

// File: rtl/drd_pkg.sv
package drd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRP_A = 2'd1,
        ST_GRP_B = 2'd2
    } drd_state_e;

    typedef enum logic [1:0] {
        SHAPE_QUIET0 = 2'b00,
        SHAPE_PULSE  = 2'b01,
        SHAPE_CLOCK  = 2'b10,
        SHAPE_QUIET1 = 2'b11
    } drd_shape_e;

    localparam int DRD_MIN_DIV = 2;

endpackage

// File: rtl/drd_cfg.sv
module drd_cfg
    import drd_pkg::*;
#(
    parameter int FW    = 12,
    parameter int REG_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cfg0_we_i,
    input  logic [REG_W-1:0] cfg0_wd_i,
    input  logic             cfg1_we_i,
    input  logic [REG_W-1:0] cfg1_wd_i,
    input  logic             load_i,
    output logic             en_o,
    output drd_shape_e       shape_o,
    output logic [FW-1:0]    n0_o,
    output logic [FW-1:0]    n1_o,
    output logic [FW-1:0]    m0_o,
    output logic [FW-1:0]    m1_o
);
    localparam int EN_BIT  = REG_W - 1;
    localparam int SHP_HI  = REG_W - 3;
    localparam int SHP_LO  = REG_W - 4;
    localparam logic [FW-1:0] MIN_N = FW'(DRD_MIN_DIV);

    logic [FW-1:0] sh_n0, sh_n1, sh_m0, sh_m1;
    logic [FW-1:0] act_n0, act_n1, act_m0, act_m1;
    logic          sh_en;
    logic [1:0]    sh_shape;
    logic          unused_cfg_bits;

    assign unused_cfg_bits = ^{cfg0_wd_i[SHP_LO-1:2*FW], cfg0_wd_i[REG_W-2],
                               cfg1_wd_i[REG_W-1:2*FW]};

    // Shadow capture: takes every write at once
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_n0    <= '0;
            sh_n1    <= '0;
            sh_shape <= '0;
            sh_en    <= 1'b0;
            sh_m0    <= '0;
            sh_m1    <= '0;
        end else begin
            if (cfg0_we_i) begin
                sh_n0    <= cfg0_wd_i[FW-1:0];
                sh_n1    <= cfg0_wd_i[2*FW-1:FW];
                sh_shape <= cfg0_wd_i[SHP_HI:SHP_LO];
                sh_en    <= cfg0_wd_i[EN_BIT];
            end
            if (cfg1_we_i) begin
                sh_m0 <= cfg1_wd_i[FW-1:0];
                sh_m1 <= cfg1_wd_i[2*FW-1:FW];
            end
        end
    end

    // Working set: only refreshed on start or pattern wrap
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            act_n0 <= MIN_N;
            act_n1 <= MIN_N;
            act_m0 <= '0;
            act_m1 <= '0;
        end else if (load_i) begin
            act_n0 <= (sh_n0 < MIN_N) ? MIN_N : sh_n0;
            act_n1 <= (sh_n1 < MIN_N) ? MIN_N : sh_n1;
            act_m0 <= sh_m0;
            act_m1 <= sh_m1;
        end
    end

    assign en_o    = sh_en;
    assign shape_o = drd_shape_e'(sh_shape);
    assign n0_o    = act_n0;
    assign n1_o    = act_n1;
    assign m0_o    = act_m0;
    assign m1_o    = act_m1;

    // R8: working set frozen between pattern boundaries
    a_r8_hold_between_groups: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> ($stable(act_n0) && $stable(act_n1) && $stable(act_m0) && $stable(act_m1)));

    // R10: working divisors never below the minimum
    a_r10_min_divisor: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (act_n0 >= MIN_N && act_n1 >= MIN_N));

endmodule

// File: rtl/drd_fsm.sv
module drd_fsm
    import drd_pkg::*;
#(
    parameter int FW = 12
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          en_i,
    input  logic [FW-1:0] n0_i,
    input  logic [FW-1:0] n1_i,
    input  logic [FW-1:0] m0_i,
    input  logic [FW-1:0] m1_i,
    output logic          run_o,
    output logic          term_o,
    output logic          load_o,
    output logic [FW-1:0] cnt_o,
    output logic [FW-1:0] half_o
);
    drd_state_e    state_q, state_d;
    logic [FW-1:0] cnt_q, rep_q;
    logic [FW-1:0] n_cur, m_cur;
    logic          run, term, last;

    always_comb begin
        n_cur = (state_q == ST_GRP_B) ? n1_i : n0_i;
        m_cur = (state_q == ST_GRP_B) ? m1_i : m0_i;
        run   = (state_q != ST_IDLE);
        term  = run && (cnt_q == n_cur - FW'(1));
        last  = term && (rep_q == m_cur);
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = ST_IDLE;                          // HALT
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_GRP_A;           // START
                ST_GRP_A: if (last) state_d = ST_GRP_B; // A_DONE
                ST_GRP_B: if (last) state_d = ST_GRP_A; // WRAP
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Period and repeat counters
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            rep_q <= '0;
        end else if (!en_i || !run) begin
            cnt_q <= '0;
            rep_q <= '0;
        end else if (term) begin
            cnt_q <= '0;
            rep_q <= last ? '0 : rep_q + FW'(1);
        end else begin
            cnt_q <= cnt_q + FW'(1);
        end
    end

    assign run_o  = run;
    assign term_o = term;
    assign load_o = en_i && ((state_q == ST_IDLE) || (state_q == ST_GRP_B && last));
    assign cnt_o  = cnt_q;
    assign half_o = n_cur >> 1;

    // R9: run bit low sends the controller to IDLE
    a_r9_idle_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (state_q == ST_IDLE));

    // R4: period counter stays inside the current divisor
    a_r4_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run |-> (cnt_q < n_cur));

    // R4: repeat counter stays inside the current group length
    a_r4_rep_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run |-> (rep_q <= m_cur));

    // R5: period ends are never back to back
    a_r5_term_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
        term |=> !term);

endmodule

// File: rtl/drd_out.sv
module drd_out
    import drd_pkg::*;
#(
    parameter int FW = 12
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          en_i,
    input  drd_shape_e    shape_i,
    input  logic          run_i,
    input  logic          term_i,
    input  logic [FW-1:0] cnt_i,
    input  logic [FW-1:0] half_i,
    output logic          div_o
);
    logic div_q;

    // Output process
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            div_q <= 1'b0;
        end else if (!en_i) begin
            div_q <= 1'b0;
        end else begin
            unique case (shape_i)
                SHAPE_PULSE: div_q <= term_i;
                SHAPE_CLOCK: div_q <= run_i && (cnt_i < half_i);
                default:     div_q <= 1'b0;
            endcase
        end
    end

    assign div_o = div_q;

    // R9: output forced low once the run bit is clear
    a_r9_out_low_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !div_o);

    // R7: quiet selector codes keep the output low
    a_r7_quiet_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shape_i == SHAPE_QUIET0 || shape_i == SHAPE_QUIET1) |=> !div_o);

endmodule

// File: rtl/dual_ratio_divider.sv
module dual_ratio_divider
    import drd_pkg::*;
#(
    parameter int FW    = 12,
    parameter int REG_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cfg0_we_i,
    input  logic [REG_W-1:0] cfg0_wd_i,
    input  logic             cfg1_we_i,
    input  logic [REG_W-1:0] cfg1_wd_i,
    output logic             div_o
);
    logic          en, run, term, load;
    drd_shape_e    shape;
    logic [FW-1:0] n0, n1, m0, m1, cnt, half;

    drd_cfg #(.FW(FW), .REG_W(REG_W)) u_cfg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cfg0_we_i (cfg0_we_i),
        .cfg0_wd_i (cfg0_wd_i),
        .cfg1_we_i (cfg1_we_i),
        .cfg1_wd_i (cfg1_wd_i),
        .load_i    (load),
        .en_o      (en),
        .shape_o   (shape),
        .n0_o      (n0),
        .n1_o      (n1),
        .m0_o      (m0),
        .m1_o      (m1)
    );

    drd_fsm #(.FW(FW)) u_fsm (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en),
        .n0_i   (n0),
        .n1_i   (n1),
        .m0_i   (m0),
        .m1_i   (m1),
        .run_o  (run),
        .term_o (term),
        .load_o (load),
        .cnt_o  (cnt),
        .half_o (half)
    );

    drd_out #(.FW(FW)) u_out (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en),
        .shape_i (shape),
        .run_i   (run),
        .term_i  (term),
        .cnt_i   (cnt),
        .half_i  (half),
        .div_o   (div_o)
    );

endmodule

// File: tb/dual_ratio_divider_tb.sv
module dual_ratio_divider_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg0_we = 1'b0, cfg1_we = 1'b0;
    logic [31:0] cfg0_wd = '0, cfg1_wd = '0;
    logic        div_o;

    int n_cmp = 0, n_bad = 0;
    int cyc = 0, wk = 0;
    int rise_t[64], fall_t[64];
    int nr = 0, nf = 0, hcnt = 0;
    logic prev = 1'b0;

    always #2.5 clk = ~clk;

    dual_ratio_divider u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .cfg0_we_i(cfg0_we), .cfg0_wd_i(cfg0_wd),
        .cfg1_we_i(cfg1_we), .cfg1_wd_i(cfg1_wd),
        .div_o(div_o)
    );

    // Output monitor, sampled at the falling edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (div_o && !prev) begin
            if (nr < 64) rise_t[nr] = cyc;
            nr = nr + 1;
        end
        if (!div_o && prev) begin
            if (nf < 64) fall_t[nf] = cyc;
            nf = nf + 1;
        end
        if (div_o) hcnt = hcnt + 1;
        prev = div_o;
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic clr();
        nr = 0; nf = 0; hcnt = 0;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr0(input logic [31:0] d);
        step(); cfg0_wd = d; cfg0_we = 1'b1; wk = cyc;
        step(); cfg0_we = 1'b0;
    endtask

    task automatic wr1(input logic [31:0] d);
        step(); cfg1_wd = d; cfg1_we = 1'b1;
        step(); cfg1_we = 1'b0;
    endtask

    function automatic logic [31:0] w0(input int n0, input int n1, input int shp, input bit en);
        return {en, 1'b0, 2'(shp), 4'hA, 12'(n1), 12'(n0)};
    endfunction

    function automatic logic [31:0] w1(input int m0, input int m1);
        return {8'h5C, 12'(m1), 12'(m0)};
    endfunction

    // Period length of the i-th period in the pattern (R4, R10)
    function automatic int per(input int i, input int n0, input int n1, input int m0, input int m1);
        int a = (n0 < 2) ? 2 : n0;
        int b = (n1 < 2) ? 2 : n1;
        int p = i % (m0 + m1 + 2);
        return (p <= m0) ? a : b;
    endfunction

    function automatic int ptime(input int t0, input int j, input int n0, input int n1, input int m0, input int m1);
        int t = t0;
        for (int i = 0; i <= j; i++) t += per(i, n0, n1, m0, m1);
        return t;
    endfunction

    task automatic disable_and_check();
        wr0(w0(3, 3, 1, 1'b0));
        clr();
        repeat (12) step();
        chk(hcnt == 0, "R9 output low after disable", hcnt, 0);
    endtask

    // Pulse-shape run: R2 R3 R4 R5
    task automatic run_pulse(input int n0, input int n1, input int m0, input int m1, input int np);
        int t0, lim, bad_j, bad_a, bad_e;
        wr1(w1(m0, m1));
        wr0(w0(n0, n1, 1, 1'b1));
        t0 = wk + 2;
        clr();
        lim = ptime(t0, np - 1, n0, n1, m0, m1) + 1;
        while (cyc < lim) step();
        bad_j = -1; bad_a = 0; bad_e = 0;
        for (int j = 0; j < np; j++) begin
            if (bad_j < 0 && rise_t[j] != ptime(t0, j, n0, n1, m0, m1)) begin
                bad_j = j; bad_a = rise_t[j]; bad_e = ptime(t0, j, n0, n1, m0, m1);
            end
        end
        chk(nr == np, "R4 pulse count", nr, np);
        chk(bad_j < 0, "R3/R4 pulse timing", bad_a, bad_e);
        chk(hcnt == nr, "R5 single-cycle pulses", hcnt, nr);
        disable_and_check();
    endtask

    initial begin
        int t0, k, r0, sum;
        // R1: reset state
        repeat (4) step();
        chk(div_o == 1'b0, "R1 low in reset", div_o, 0);
        rst_n = 1'b1;
        clr();
        repeat (20) step();
        chk(hcnt == 0, "R1 low after reset", hcnt, 0);

        // R3: run bit clear keeps divider off (also other bits set: R2)
        wr1(w1(0, 0));
        wr0(w0(2, 2, 1, 1'b0) | 32'h4F00_0000);
        clr();
        repeat (40) step();
        chk(hcnt == 0, "R3 no output while disabled", hcnt, 0);

        // Sweep: R2 R4 R5 R9
        for (int a = 2; a <= 5; a++)
            for (int b = 2; b <= 5; b++)
                for (int c = 0; c <= 2; c++)
                    for (int d = 0; d <= 2; d++)
                        run_pulse(a, b, c, d, 10);

        // Large divisors near the nominal setting
        run_pulse(733, 732, 1, 2, 6);

        // R10: divisor fields 0 and 1 act as 2
        run_pulse(0, 1, 0, 0, 8);
        run_pulse(1, 3, 1, 0, 8);

        // R6: clock shape, odd and even divisors
        wr1(w1(0, 1));
        wr0(w0(7, 6, 2, 1'b1));
        r0 = wk + 3;
        clr();
        sum = 0;
        for (int j = 0; j < 8; j++) sum += per(j, 7, 6, 0, 1);
        while (cyc < r0 + sum - 1) step();
        chk(nr == 8, "R6 clock rise count", nr, 8);
        sum = 0;
        for (int j = 0; j < 8; j++) begin
            chk(rise_t[j] == r0 + sum, "R6 clock rise time", rise_t[j], r0 + sum);
            chk(fall_t[j] == r0 + sum + (per(j, 7, 6, 0, 1) >> 1), "R6 clock high width",
                fall_t[j] - rise_t[j], per(j, 7, 6, 0, 1) >> 1);
            sum += per(j, 7, 6, 0, 1);
        end
        disable_and_check();

        // R7: quiet selector codes, divider keeps running
        wr1(w1(0, 0));
        wr0(w0(3, 3, 0, 1'b1));
        clr();
        repeat (30) step();
        chk(hcnt == 0, "R7 selector 00 quiet", hcnt, 0);
        wr0(w0(3, 3, 3, 1'b1));
        clr();
        repeat (30) step();
        chk(hcnt == 0, "R7 selector 11 quiet", hcnt, 0);
        wr0(w0(3, 3, 1, 1'b1));
        clr();
        repeat (4) step();
        chk(nr >= 1, "R7 pulses resume without restart", nr, 1);
        disable_and_check();

        // R8: new settings wait for the pattern end (5,5,4,4 then 3,2)
        wr1(w1(1, 1));
        wr0(w0(5, 4, 1, 1'b1));
        t0 = wk + 2;
        clr();
        while (nr < 1) step();
        wr0(w0(3, 2, 1, 1'b1));
        wr1(w1(0, 0));
        while (cyc < t0 + 29) step();
        k = 0;
        foreach (rise_t[j]) if (j < 8) begin
            int e;
            case (j)
                0: e = 5;  1: e = 10; 2: e = 14; 3: e = 18;
                4: e = 21; 5: e = 23; 6: e = 26; default: e = 28;
            endcase
            chk(rise_t[j] == t0 + e, "R8 boundary update timing", rise_t[j], t0 + e);
        end

        // R9: re-enable restarts with an N0 group
        disable_and_check();
        wr0(w0(4, 2, 1, 1'b1));
        t0 = wk + 2;
        clr();
        while (cyc < t0 + 9) step();
        chk(rise_t[0] == t0 + 4, "R9 restart first N0", rise_t[0], t0 + 4);
        chk(rise_t[1] == t0 + 6, "R9 restart then N1", rise_t[1], t0 + 6);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        #(5 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule